// File: doc/BRIEF.md
# Receive Character Buffer with Automatic Flow Control

This block sits between the serial receiver of one UART channel and the host. The receiver pushes each character into it as an 8-bit data byte with three error flags: parity, framing and break. The host pops the characters in arrival order, and each one comes back with its own flags. The buffer reports whether data is waiting, how many characters it holds, and whether a character was lost because the buffer was full.

With the FIFO enable low, the buffer holds only one character. This is the state after reset. With the FIFO enable high, it holds up to sixteen characters. In that mode an automatic flow-control feature can drive the active-low request-to-send output. The output goes high to ask the remote sender to pause once the fill count reaches a selectable threshold. It goes low again only after the host has drained the buffer completely. This stops the remote end before any character is dropped.

A one-cycle flush empties the buffer. A change of the FIFO enable in either direction also empties it. The overrun indication stays set until reset.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset, count_o is 0, data_rdy_o is 0, overrun_o is 0, rts_no is 0, and rd_data_o and rd_err_o are 0.
- R2: With fifo_en_i high, the buffer accepts up to DEPTH (16) characters and returns them in arrival order. Each data byte comes back with its own error bits, where bit 0 is parity, bit 1 is framing and bit 2 is break.
- R3: A write while the buffer is at capacity discards the new character, keeps the stored characters, and sets overrun_o. overrun_o then stays high until reset.
- R4: With fifo_en_i low, the capacity is one character, so a second write before a read is an overrun.
- R5: A read of a non-empty buffer places the oldest character on rd_data_o/rd_err_o at the next clock edge. A read of an empty buffer leaves rd_data_o, rd_err_o and count_o unchanged.
- R6: A one-cycle flush_i sets count_o to 0 at the next edge and leaves overrun_o unchanged. A write or read in the same cycle as the flush is ignored.
- R7: A change of fifo_en_i in either direction empties the buffer at the next edge. A write or read in that cycle is ignored.
- R8: trig_sel_i selects the threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 characters.
- R9: With auto_rts_en_i and fifo_en_i both high, rts_no goes high at the edge where the count reaches the threshold. It stays high until the edge where the count becomes 0.
- R10: When auto_rts_en_i or fifo_en_i is low, rts_no is low after the next edge.
- R11: data_rdy_o is high exactly when count_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1: sixteen-entry mode, 0: single-character mode |
| auto_rts_en_i | input | 1 | Enables automatic request-to-send control |
| trig_sel_i | input | 2 | Threshold select (1/4/8/14) |
| flush_i | input | 1 | Empties the buffer |
| wr_en_i | input | 1 | Receiver write strobe |
| wr_data_i | input | 8 | Received data byte |
| wr_err_i | input | 3 | Error flags: bit0 parity, bit1 framing, bit2 break |
| rd_en_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Last character read |
| rd_err_o | output | 3 | Error flags of the last character read |
| data_rdy_o | output | 1 | Buffer is not empty |
| count_o | output | 5 | Number of stored characters |
| overrun_o | output | 1 | Sticky flag: a character was lost |
| rts_no | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with the default depth of 16 and an 8-bit data byte. With that depth, every threshold setting can be reached, including 14, and the bench can drive the buffer to full and past it. Constrained random traffic switches modes, thresholds and flushes while a bench model follows order, count, overrun and flow-control state. Directed runs cover each threshold edge, the drain-to-empty release, single-character overrun, and reads of an empty buffer.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;
  localparam int CHAR_W = 8;
  localparam int ERR_W  = 3;
  localparam int ENT_W  = CHAR_W + ERR_W;

  typedef struct packed {
    logic [ERR_W-1:0]  err;   // bit0 parity, bit1 framing, bit2 break
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  function automatic int trig_level(logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    count_next_o = cnt_q;
    if (clr_i)                count_next_o = '0;
    else if (push_i && !pop_i) count_next_o = cnt_q + 1'b1;
    else if (pop_i && !push_i) count_next_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= count_next_o;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rx_rts_ctl.sv
module rx_rts_ctl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] thr_i,
  input  logic [CNT_W-1:0] count_next_i,
  output logic             rts_no
);
  logic hold_q;

  // set on reaching threshold, released only once drained
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= en_i && (count_next_i != '0) &&
                           ((count_next_i >= thr_i) || hold_q);
  end

  assign rts_no = hold_q;
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
  import rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              auto_rts_en_i,
  input  logic [1:0]        trig_sel_i,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic [ERR_W-1:0]  wr_err_i,
  input  logic              rd_en_i,
  output logic [CHAR_W-1:0] rd_data_o,
  output logic [ERR_W-1:0]  rd_err_o,
  output logic              data_rdy_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              overrun_o,
  output logic              rts_no
);
  logic             fifo_en_q, clr, full, push, pop, ovr_q;
  logic [CNT_W-1:0] cnt, cnt_next, cap, thr;
  rx_char_t         wr_ent, head, rd_q;

  assign clr    = flush_i || (fifo_en_i != fifo_en_q);
  assign cap    = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full   = cnt >= cap;
  assign push   = wr_en_i && !full && !clr;
  assign pop    = rd_en_i && (cnt != '0) && !clr;
  assign wr_ent = '{err: wr_err_i, data: wr_data_i};
  assign thr    = (trig_level(trig_sel_i) > DEPTH) ? CNT_W'(DEPTH)
                                                   : CNT_W'(trig_level(trig_sel_i));

  rx_fifo_store #(.DEPTH(DEPTH), .W(ENT_W)) store_i (
    .clk_i, .rst_ni,
    .clr_i        (clr),
    .push_i       (push),
    .pop_i        (pop),
    .din_i        (wr_ent),
    .head_o       (head),
    .count_o      (cnt),
    .count_next_o (cnt_next)
  );

  rx_rts_ctl #(.CNT_W(CNT_W)) rts_i (
    .clk_i, .rst_ni,
    .en_i         (auto_rts_en_i && fifo_en_i),
    .thr_i        (thr),
    .count_next_i (cnt_next),
    .rts_no       (rts_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q <= 1'b0;
      ovr_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      fifo_en_q <= fifo_en_i;
      if (wr_en_i && full && !clr) ovr_q <= 1'b1;
      if (pop) rd_q <= head;
    end
  end

  assign rd_data_o  = rd_q.data;
  assign rd_err_o   = rd_q.err;
  assign count_o    = cnt;
  assign data_rdy_o = cnt != '0;
  assign overrun_o  = ovr_q;
endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_en_i,
  input logic             auto_rts_en_i,
  input logic             flush_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [7:0]       rd_data_o,
  input logic [2:0]       rd_err_o,
  input logic             data_rdy_o,
  input logic [CNT_W-1:0] count_o,
  input logic             overrun_o,
  input logic             rts_no
);
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  assert_single_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_en_i && !$past(fifo_en_i)) |-> count_o <= CNT_W'(1));

  assert_overrun_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_full_write_ovr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && fifo_en_i && count_o == CNT_W'(DEPTH) && !flush_i) |=> overrun_o);

  assert_full_write_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && fifo_en_i && count_o == CNT_W'(DEPTH) && !flush_i)
      |=> count_o == CNT_W'(DEPTH));

  assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_o == '0);

  assert_empty_read_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && count_o == '0) |=> ($stable(rd_data_o) && $stable(rd_err_o)));

  assert_rts_needs_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts_no |-> count_o != '0);

  assert_rts_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(auto_rts_en_i && fifo_en_i) |=> !rts_no);

  assert_rdy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o |-> count_o != '0);
endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i, .rst_ni, .fifo_en_i, .auto_rts_en_i, .flush_i, .wr_en_i, .rd_en_i,
  .rd_data_o, .rd_err_o, .data_rdy_o, .count_o, .overrun_o, .rts_no
);

// File: tb/rx_fifo_rts_tb.sv
module rx_fifo_rts_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, auto_en = 0, flush = 0, wr_en = 0, rd_en = 0;
  logic [1:0] sel = 0;
  logic [7:0] wd = 0;
  logic [2:0] we = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic rdy, ovr, rts_n;
  logic [4:0] cnt;

  int total = 0, bad = 0;
  logic [10:0] m_q[$];
  logic [10:0] m_rd;
  bit m_ovr, m_hold, m_prev_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_fifo_rts #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .auto_rts_en_i(auto_en),
    .trig_sel_i(sel), .flush_i(flush), .wr_en_i(wr_en), .wr_data_i(wd),
    .wr_err_i(we), .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_err_o(rd_err),
    .data_rdy_o(rdy), .count_o(cnt), .overrun_o(ovr), .rts_no(rts_n)
  );

  function automatic int thr_of(logic [1:0] s);  // R8
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic check_eq(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_q.delete(); m_rd = 0; m_ovr = 0; m_hold = 0; m_prev_en = 0;
  endtask

  task automatic model_step();
    int cap, n;
    bit clr;
    clr = flush || (fifo_en != m_prev_en);
    cap = fifo_en ? DEPTH : 1;
    if (clr) m_q.delete();
    else begin
      n = m_q.size();
      if (wr_en && n >= cap) m_ovr = 1;
      if (rd_en && n > 0) m_rd = m_q.pop_front();
      if (wr_en && n < cap) m_q.push_back({we, wd});
    end
    n = m_q.size();
    m_hold = auto_en && fifo_en && n != 0 && (n >= thr_of(sel) || m_hold);
    m_prev_en = fifo_en;
  endtask

  task automatic compare_all();
    check_eq("R2 count", cnt, m_q.size());
    check_eq("R11 data_rdy", rdy, m_q.size() != 0);
    check_eq("R3 overrun", ovr, m_ovr);
    check_eq("R5 rd_data", rd_data, m_rd[7:0]);
    check_eq("R2 rd_err", rd_err, m_rd[10:8]);
    check_eq("R9 rts", rts_n, m_hold);
  endtask

  task automatic step(bit w, bit [10:0] d, bit r, bit f);
    wr_en = w; {we, wd} = d; rd_en = r; flush = f;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; rd_en = 0; flush = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; fifo_en = 0; auto_en = 0; sel = 0;
    wr_en = 0; rd_en = 0; flush = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_1234);
    do_reset();
    @(negedge clk);
    check_eq("R1 count", cnt, 0);
    check_eq("R1 rdy", rdy, 0);
    check_eq("R1 ovr", ovr, 0);
    check_eq("R1 rts", rts_n, 0);
    check_eq("R1 rd", {rd_err, rd_data}, 0);

    // single-character mode
    step(1, 11'h5A1, 0, 0);
    step(1, 11'h0B2, 0, 0);
    check_eq("R4 count", cnt, 1);
    check_eq("R4 ovr", ovr, 1);
    step(0, 0, 1, 0);
    check_eq("R4 rd", {rd_err, rd_data}, 11'h5A1);

    // sixteen-entry mode, threshold 14
    do_reset();
    fifo_en = 1; auto_en = 1; sel = 3;
    step(0, 0, 0, 0);
    for (int i = 0; i < 13; i++) step(1, 11'(i * 37 + 1), 0, 0);
    check_eq("R8 rts below 14", rts_n, 0);
    step(1, 11'h7FE, 0, 0);
    check_eq("R9 rts at 14", rts_n, 1);
    step(1, 11'h100, 0, 0);
    step(1, 11'h200, 0, 0);
    step(1, 11'h3FF, 0, 0);
    check_eq("R3 count kept", cnt, 16);
    check_eq("R3 ovr", ovr, 1);
    for (int i = 0; i < 15; i++) step(0, 0, 1, 0);
    check_eq("R9 rts held", rts_n, 1);
    step(0, 0, 1, 0);
    check_eq("R9 rts released", rts_n, 0);
    check_eq("R2 last", {rd_err, rd_data}, 11'h200);
    step(0, 0, 1, 0);
    check_eq("R5 empty read", {rd_err, rd_data}, 11'h200);

    // auto off, flush
    auto_en = 0;
    for (int i = 0; i < 15; i++) step(1, 11'(i), 0, 0);
    check_eq("R10 rts off", rts_n, 0);
    step(1, 11'h055, 1, 1);
    check_eq("R6 flush count", cnt, 0);
    check_eq("R6 ovr kept", ovr, 1);

    // mode change empties
    for (int i = 0; i < 3; i++) step(1, 11'(i + 9), 0, 0);
    fifo_en = 0;
    step(0, 0, 0, 0);
    check_eq("R7 mode change", cnt, 0);

    // thresholds 1, 4, 8
    fifo_en = 1; auto_en = 1;
    for (int s = 0; s < 3; s++) begin
      sel = 2'(s);
      step(0, 0, 0, 1);
      for (int i = 0; i < thr_of(2'(s)) - 1; i++) step(1, 11'(i), 0, 0);
      check_eq("R8 below", rts_n, 0);
      step(1, 11'h0AA, 0, 0);
      check_eq("R8 reached", rts_n, 1);
    end

    // random traffic
    for (int it = 0; it < 6000; it++) begin
      if (it % 700 == 0) do_reset();
      if ($urandom_range(99) < 2) fifo_en = ~fifo_en;
      if ($urandom_range(99) < 3) auto_en = ~auto_en;
      if ($urandom_range(99) < 3) sel = 2'($urandom_range(3));
      step($urandom_range(99) < 55, 11'($urandom), $urandom_range(99) < 45,
           $urandom_range(199) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule